// File: doc/BRIEF.md
# Graphics Engine Interrupt Controller

This block collects the three interrupt sources of a graphics engine (binning flush finished, render frame finished, and binner starved of memory) and presents them to the processor as one level-sensitive interrupt line. Software sees a small register window on a simple bus with a write strobe, a byte address, write data and combinational read data. It acknowledges pending interrupts by writing ones to a status register. It changes individual enable bits through a set port and a clear port, so no read-modify-write is needed.

The two finishing sources are latched events: a pulse sets the pending bit, and it stays set until software acknowledges it. The starvation source is a condition rather than an event. Once it is raised, the pending bit keeps coming back until software hands the binner a fresh overflow pool by writing a nonzero pool size. Only after that does an acknowledge take effect. Coming out of reset, the binner is taken to have no pool.

Top module: `gfx_irq_ctrl`

## Requirements
- R1: After reset the status, enable, pool-address and pool-size registers all read 0 and `irq` is low.
- R2: Status bit 0 is the flush event and bit 1 the frame event. A write to offset 0x00 with a 1 in one of these bits clears that bit in the next cycle, and a 0 in a bit leaves it unchanged.
- R3: A write to offset 0x04 sets every enable bit that is 1 in the write data and leaves the other enable bits alone. Enable bit n gates status bit n.
- R4: A write to offset 0x08 clears every enable bit that is 1 in the write data and leaves the other enable bits alone.
- R5: Reads of offset 0x04 and of offset 0x08 both return the current enable bits.
- R6: Status bits latch whatever the enable state is, and `irq` is high exactly when the AND of status and enable is nonzero.
- R7: When an event pulse and a write-1 acknowledge of the same bit fall in the same cycle, the bit stays set.
- R8: While the starvation condition is present, status bit 2 is set one cycle later and a write-1 acknowledge of it has no effect. The condition is present from reset.
- R9: A write of a nonzero value to the pool-size register at 0x10 removes the condition, and a later acknowledge of bit 2 then clears it. A zero size write does not remove the condition. A pulse on `oom_req` raises the condition again, and it wins over a size write in the same cycle.
- R10: Offset 0x0C holds the pool address and reads back what was written. Reads of any offset other than 0x00, 0x04, 0x08, 0x0C and 0x10 return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for `bus_addr` |
| ev_flush | input | 1 | One-cycle pulse: binning flush finished |
| ev_frame | input | 1 | One-cycle pulse: render frame finished |
| oom_req | input | 1 | One-cycle pulse: binner ran out of memory |
| irq | output | 1 | Level interrupt to the processor |

## Verification
The bench first targets the starvation bit. It acknowledges bit 2 while the condition holds, writes a zero size, and then writes a nonzero size. A design that treats bit 2 as an ordinary event would lose the interrupt on the first acknowledge, and one that never looks at the size value would release on the zero write. It also fires an event in the same cycle as its acknowledge, where a design that gives the clear priority drops the event. It reads the enables through both offsets after set and clear writes that carry zero bits, which exposes a design that overwrites instead of masking. A long stretch of random traffic is compared against a behavioural model on every clock, so `irq` is also checked with events latched behind disabled enables.

// File: rtl/gfx_irq_ctrl.sv
module gfx_irq_ctrl #(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              ev_flush,
  input  logic              ev_frame,
  input  logic              oom_req,
  output logic              irq
);
  localparam int NSRC = 3;
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(5'h00);
  localparam logic [ADDR_W-1:0] A_ESET = ADDR_W'(5'h04);
  localparam logic [ADDR_W-1:0] A_ECLR = ADDR_W'(5'h08);
  localparam logic [ADDR_W-1:0] A_PADR = ADDR_W'(5'h0C);
  localparam logic [ADDR_W-1:0] A_PSIZ = ADDR_W'(5'h10);

  logic [NSRC-1:0]   pend, en;
  logic [DATA_W-1:0] pool_addr, pool_size;
  logic              oom_cause;

  wire             wr_stat = bus_wr && bus_addr == A_STAT;
  wire             wr_eset = bus_wr && bus_addr == A_ESET;
  wire             wr_eclr = bus_wr && bus_addr == A_ECLR;
  wire             wr_psiz = bus_wr && bus_addr == A_PSIZ;
  wire [NSRC-1:0]  ack     = wr_stat ? bus_wdata[NSRC-1:0] : '0;
  wire [NSRC-1:0]  raise   = {oom_cause, ev_frame, ev_flush};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) pend <= '0;
    else        pend <= raise | (pend & ~ack);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)       en <= '0;
    else if (wr_eset) en <= en | bus_wdata[NSRC-1:0];
    else if (wr_eclr) en <= en & ~bus_wdata[NSRC-1:0];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      pool_addr <= '0;
      pool_size <= '0;
      oom_cause <= 1'b1;
    end else begin
      if (bus_wr && bus_addr == A_PADR) pool_addr <= bus_wdata;
      if (wr_psiz) pool_size <= bus_wdata;
      oom_cause <= oom_req | (oom_cause & ~(wr_psiz && bus_wdata != '0));
    end

  always_comb
    case (bus_addr)
      A_STAT:         bus_rdata = {{(DATA_W-NSRC){1'b0}}, pend};
      A_ESET, A_ECLR: bus_rdata = {{(DATA_W-NSRC){1'b0}}, en};
      A_PADR:         bus_rdata = pool_addr;
      A_PSIZ:         bus_rdata = pool_size;
      default:        bus_rdata = '0;
    endcase

  assign irq = |(pend & en);
endmodule

// File: rtl/gfx_irq_ctrl_chk.sv
module gfx_irq_ctrl_chk #(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic              ev_flush,
  input logic              ev_frame,
  input logic              oom_req,
  input logic              irq,
  input logic [2:0]        pend,
  input logic [2:0]        en,
  input logic              oom_cause
);
  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == ADDR_W'(0) && bus_wdata[0] && !ev_flush) |=> !pend[0]); // R2
  AST_ENA_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == ADDR_W'(4) && bus_wdata[1]) |=> en[1]); // R3
  AST_ENA_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == ADDR_W'(8) && bus_wdata[1]) |=> !en[1]); // R4
  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (en == 3'b000) |-> !irq); // R6
  AST_FLUSH_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    ev_flush |=> pend[0]); // R7
  AST_FRAME_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    ev_frame |=> pend[1]); // R7
  AST_OOM_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    oom_cause |=> pend[2]); // R8
  AST_OOM_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == ADDR_W'(5'h10) && bus_wdata != '0 && !oom_req) |=> !oom_cause); // R9
  AST_OOM_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
    oom_req |=> oom_cause); // R9
endmodule

bind gfx_irq_ctrl gfx_irq_ctrl_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) chk_i (.*);

// File: tb/gfx_irq_ctrl_tb_top.sv
`timescale 1ns/1ps
module gfx_irq_ctrl_tb_top;
  logic        clk = 0, rst_n = 0;
  logic        bus_wr = 0, ev_flush = 0, ev_frame = 0, oom_req = 0;
  logic [4:0]  bus_addr = 0;
  logic [31:0] bus_wdata = 0, bus_rdata;
  logic        irq;
  int n_run = 0, n_fail = 0;
  bit done = 0;

  logic [2:0]  m_pend = 0, m_en = 0;
  logic [31:0] m_addr = 0, m_size = 0;
  bit          m_cause = 1;

  always #2 clk = ~clk;

  gfx_irq_ctrl dut_i (.*);

  function automatic logic [31:0] m_read(logic [4:0] a);
    case (a)
      5'h00: return {29'b0, m_pend};
      5'h04, 5'h08: return {29'b0, m_en};
      5'h0C: return m_addr;
      5'h10: return m_size;
      default: return 32'b0;
    endcase
  endfunction

  task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
    end
  endtask

  task automatic model_edge();
    logic [2:0] ack;
    bit cause_n;
    ack = (bus_wr && bus_addr == 5'h00) ? bus_wdata[2:0] : 3'b0;
    cause_n = oom_req || (m_cause && !(bus_wr && bus_addr == 5'h10 && bus_wdata != 0));
    m_pend = {m_cause, ev_frame, ev_flush} | (m_pend & ~ack);
    if (bus_wr && bus_addr == 5'h04) m_en = m_en | bus_wdata[2:0];
    if (bus_wr && bus_addr == 5'h08) m_en = m_en & ~bus_wdata[2:0];
    if (bus_wr && bus_addr == 5'h0C) m_addr = bus_wdata;
    if (bus_wr && bus_addr == 5'h10) m_size = bus_wdata;
    m_cause = cause_n;
  endtask

  task automatic step(string tag, bit wr, logic [4:0] a, logic [31:0] d,
                      bit fl = 0, bit fr = 0, bit om = 0);
    bus_wr = wr; bus_addr = a; bus_wdata = d;
    ev_flush = fl; ev_frame = fr; oom_req = om;
    @(posedge clk);
    model_edge();
    @(negedge clk);
    bus_wr = 0; ev_flush = 0; ev_frame = 0; oom_req = 0;
    check({tag, " R6 irq"}, {31'b0, irq}, {31'b0, |(m_pend & m_en)});
    check({tag, " readback"}, bus_rdata, m_read(a));
  endtask

  task automatic rd(string tag, logic [4:0] a, logic [31:0] exp);
    step(tag, 0, a, 0);
    check({tag, " spec"}, bus_rdata, exp);
  endtask

  initial begin
    @(negedge clk);
    bus_addr = 5'h00;
    #0.1 check("R1 status in reset", bus_rdata, 0);
    check("R1 irq in reset", {31'b0, irq}, 0);
    @(negedge clk) rst_n = 1;
    rd("R8 oom pending from reset", 5'h00, 32'h4);
    rd("R1 enables zero", 5'h04, 0);
    rd("R1 pool addr zero", 5'h0C, 0);
    rd("R1 pool size zero", 5'h10, 0);
    step("R8 ack while starved", 1, 5'h00, 32'h4);
    rd("R8 bit2 still set", 5'h00, 32'h4);
    step("R3 enable oom", 1, 5'h04, 32'h4);
    check("R3 irq on", {31'b0, irq}, 1);
    step("R3 zero bits no effect", 1, 5'h04, 32'h0);
    rd("R5 read via clear offset", 5'h08, 32'h4);
    step("R6 flush while disabled", 0, 5'h00, 0, 1);
    rd("R6 flush latched", 5'h00, 32'h5);
    step("R2 ack with zeros", 1, 5'h00, 32'h0);
    rd("R2 unchanged", 5'h00, 32'h5);
    step("R2 ack flush", 1, 5'h00, 32'h1);
    rd("R2 flush cleared", 5'h00, 32'h4);
    step("R7 frame with ack", 1, 5'h00, 32'h2, 0, 1);
    rd("R7 frame kept", 5'h00, 32'h6);
    step("R4 clear oom enable", 1, 5'h08, 32'h4);
    rd("R4 enable gone", 5'h04, 32'h0);
    check("R4 irq off", {31'b0, irq}, 0);
    step("R3 enable frame", 1, 5'h04, 32'h2);
    check("R6 irq from frame", {31'b0, irq}, 1);
    step("R9 zero size", 1, 5'h10, 32'h0);
    step("R9 ack after zero size", 1, 5'h00, 32'h4);
    rd("R9 still starved", 5'h00, 32'h6);
    step("R10 pool addr", 1, 5'h0C, 32'h8000_1000);
    rd("R10 addr back", 5'h0C, 32'h8000_1000);
    step("R9 size write", 1, 5'h10, 32'h0001_0000);
    step("R9 ack after size", 1, 5'h00, 32'h4);
    rd("R9 oom cleared", 5'h00, 32'h2);
    rd("R9 size back", 5'h10, 32'h0001_0000);
    rd("R10 hole 0x14", 5'h14, 0);
    rd("R10 hole 0x1C", 5'h1C, 0);
    step("R9 oom raised again", 0, 5'h00, 0, 0, 0, 1);
    step("R9 cause latency", 0, 5'h00, 0);
    rd("R9 bit2 back", 5'h00, 32'h6);
    step("R9 raise beats size", 1, 5'h10, 32'h40, 0, 0, 1);
    step("R9 ack still starved", 1, 5'h00, 32'h4);
    rd("R9 bit2 kept", 5'h00, 32'h6);
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] r;
      r = $urandom;
      step("R6 random", r[0] & r[1], {r[4:2], 2'b00},
           (r[7:5] == 3'd5) ? 32'h20 : {29'b0, r[10:8]},
           r[11] & r[12], r[13] & r[14], r[15] & r[16] & r[17]);
    end
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule